// File: doc/BRIEF.md
# Binary Template Window Scorer

The block scores one square window of unsigned 8-bit pixels against a pair of one-bit masks. The bright mask marks positions where a strong return is expected and the surround mask marks positions where absorption is expected. A host streams the window and both masks in one row per beat. The block keeps the population of each mask as the rows arrive. After a start pulse it runs four fixed steps. First it sums the pixels under the bright mask. It divides that sum by the bright population and subtracts a signed bias to get a per-window threshold. It then counts the bright positions at or above the threshold and the surround positions below it. Last it combines the two counts into a hit-quality score.

The load port is valid/ready. A beat moves only in a cycle where both `in_valid` and `in_ready` are high. The host must hold a beat and its data stable until it is taken. `in_ready` falls in the cycle `start` is high and stays low while a window is being scored, so the stored window cannot change under a running score. Start, bias and the results are plain pins. The results hold their values until the next `done` pulse.

The score comes out in two forms: an exact fraction (`hq_num` / `hq_den`) and an unsigned fixed-point value with 16 fractional bits. A window whose bright or surround mask is empty raises `err` instead of dividing by zero.

Top module: `wsc_window_scorer`

## Requirements
- R1: Each accepted beat writes the next row, starting at row 0 after reset and wrapping after row 7. Pixel column c of the row sits in `in_pix[8c+7:8c]`. Column c of each mask row is bit c of `in_bright` / `in_surr`. The mask populations BC and SC come from the beats, not from the host.
- R2: `in_ready` is 0 in any cycle where `start` is 1 and in the three cycles after an accepted start. Otherwise it is 1. A beat offered while `in_ready` is 0 is not taken and does not change the result being computed. It is taken later, once the host has held it until `in_ready` returns.
- R3: `start` is accepted only while no window is being scored, and a start seen during scoring is ignored. `done` is high for exactly one cycle: the fourth cycle after the cycle of the accepted start.
- R4: The threshold is floor(S / BC) minus bias. S is the sum of the pixels whose bright bit is 1, and the bias is the signed value on `bias` in the start cycle.
- R5: `bright_cnt` is the number of bright-mask positions whose pixel is greater than or equal to the threshold. A negative threshold makes it equal BC.
- R6: `surr_cnt` is the number of surround-mask positions whose pixel is strictly less than the threshold. A negative threshold makes it 0.
- R7: `hq_num` = bright_cnt*SC + surr_cnt*BC and `hq_den` = 2*BC*SC.
- R8: `hq_score` = floor(hq_num * 65536 / hq_den). Its largest value is 65536, which stands for 1.0.
- R9: If BC or SC is 0, `err` is 1, and `bright_cnt`, `surr_cnt`, `hq_num`, `hq_den` and `hq_score` are all 0. Otherwise `err` is 0.
- R10: After reset all result outputs are 0 and `in_ready` is 1. Between `done` pulses the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Load beat offered |
| in_ready | output | 1 | Load beat can be taken this cycle |
| in_pix | input | 64 | Eight pixels of one row, column c at bits 8c+7..8c |
| in_bright | input | 8 | Bright mask row, bit c = column c |
| in_surr | input | 8 | Surround mask row, bit c = column c |
| bias | input | 12 | Signed bias subtracted from the threshold |
| start | input | 1 | Start scoring the stored window |
| done | output | 1 | One-cycle pulse when results update |
| err | output | 1 | An empty bright or surround mask |
| bright_cnt | output | 7 | Bright positions at or above the threshold |
| surr_cnt | output | 7 | Surround positions below the threshold |
| hq_num | output | 14 | Hit-quality numerator |
| hq_den | output | 14 | Hit-quality denominator |
| hq_score | output | 17 | Hit quality, unsigned, 16 fractional bits |

## Verification
The hardest case to reach from the ports is a load beat that arrives while a window is being scored. The stall must not leak into the running result, and the beat must not be lost. The bench starts a score and offers the first row of a new window on the very next cycle. It holds that beat through the stall and then completes the reload. Its per-cycle model shows that the old result comes out unchanged and the new window scores correctly. Threshold corner cases are reached through the bias pin and chosen pixel values. These are: a pixel exactly equal to the threshold, a negative threshold, a threshold above every pixel, and a full score of 1.0.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  // Default geometry of the scorer.
  parameter int WSC_DIM    = 8;
  parameter int WSC_PIX_W  = 8;
  parameter int WSC_BIAS_W = 12;
  parameter int WSC_FRAC_W = 16;
endpackage

// File: rtl/wsc_loader.sv
// Row-by-row window and mask store with running mask populations.
module wsc_loader #(
  parameter int DIM   = 8,
  parameter int PIX_W = 8,
  localparam int CELLS = DIM * DIM,
  localparam int CNT_W = $clog2(CELLS + 1),
  localparam int ROW_W = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [DIM*PIX_W-1:0]             row_pix,
  input  logic [DIM-1:0]                   row_bright,
  input  logic [DIM-1:0]                   row_surr,
  output logic [DIM-1:0][DIM*PIX_W-1:0]    pix_rows,
  output logic [DIM-1:0][DIM-1:0]          bmask_rows,
  output logic [DIM-1:0][DIM-1:0]          smask_rows,
  output logic [CNT_W-1:0]                 bc,
  output logic [CNT_W-1:0]                 sc
);
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] pop_b, pop_s;
  logic             first_row;

  assign first_row = (row_q == '0);

  always_comb begin
    pop_b = '0;
    pop_s = '0;
    for (int c = 0; c < DIM; c++) begin
      pop_b = pop_b + CNT_W'(row_bright[c]);
      pop_s = pop_s + CNT_W'(row_surr[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      bc    <= '0;
      sc    <= '0;
    end else if (wr) begin
      row_q <= (row_q == ROW_W'(DIM - 1)) ? '0 : row_q + ROW_W'(1);
      bc    <= (first_row ? '0 : bc) + pop_b;
      sc    <= (first_row ? '0 : sc) + pop_s;
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pix_rows[r]   <= '0;
        bmask_rows[r] <= '0;
        smask_rows[r] <= '0;
      end else if (wr && row_q == ROW_W'(r)) begin
        pix_rows[r]   <= row_pix;
        bmask_rows[r] <= row_bright;
        smask_rows[r] <= row_surr;
      end
    end
  end
endmodule

// File: rtl/wsc_shape_sum.sv
// Sum of the pixels selected by the bright mask.
module wsc_shape_sum #(
  parameter int DIM   = 8,
  parameter int PIX_W = 8,
  localparam int CELLS = DIM * DIM,
  localparam int SUM_W = PIX_W + $clog2(CELLS)
) (
  input  logic [DIM-1:0][DIM*PIX_W-1:0] pix_rows,
  input  logic [DIM-1:0][DIM-1:0]       bmask_rows,
  output logic [SUM_W-1:0]              sum
);
  always_comb begin
    sum = '0;
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        if (bmask_rows[r][c]) sum = sum + SUM_W'(pix_rows[r][c*PIX_W +: PIX_W]);
      end
    end
  end
endmodule

// File: rtl/wsc_masked_count.sv
// Bright hits (pixel >= threshold) and surround hits (pixel < threshold).
module wsc_masked_count #(
  parameter int DIM   = 8,
  parameter int PIX_W = 8,
  parameter int TH_W  = 16,
  localparam int CELLS = DIM * DIM,
  localparam int CNT_W = $clog2(CELLS + 1)
) (
  input  logic [DIM-1:0][DIM*PIX_W-1:0] pix_rows,
  input  logic [DIM-1:0][DIM-1:0]       bmask_rows,
  input  logic [DIM-1:0][DIM-1:0]       smask_rows,
  input  logic signed [TH_W-1:0]        thr,
  output logic [CNT_W-1:0]              bs,
  output logic [CNT_W-1:0]              ss
);
  logic signed [TH_W-1:0] pixv;

  always_comb begin
    bs   = '0;
    ss   = '0;
    pixv = '0;
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        pixv = $signed({{(TH_W-PIX_W){1'b0}}, pix_rows[r][c*PIX_W +: PIX_W]});
        if (bmask_rows[r][c] && (pixv >= thr)) bs = bs + CNT_W'(1);
        if (smask_rows[r][c] && (pixv <  thr)) ss = ss + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wsc_quality.sv
// Exact hit-quality fraction and its fixed-point quotient.
module wsc_quality #(
  parameter int DIM    = 8,
  parameter int FRAC_W = 16,
  localparam int CELLS   = DIM * DIM,
  localparam int CNT_W   = $clog2(CELLS + 1),
  localparam int HQ_W    = $clog2(2 * CELLS * CELLS + 1),
  localparam int SCORE_W = FRAC_W + 1,
  localparam int QW      = HQ_W + FRAC_W
) (
  input  logic [CNT_W-1:0]   bs,
  input  logic [CNT_W-1:0]   ss,
  input  logic [CNT_W-1:0]   bc,
  input  logic [CNT_W-1:0]   sc,
  output logic               err,
  output logic [HQ_W-1:0]    num,
  output logic [HQ_W-1:0]    den,
  output logic [SCORE_W-1:0] score
);
  logic [QW-1:0] dividend, divisor;

  assign err = (bc == '0) || (sc == '0);

  always_comb begin
    num = '0;
    den = '0;
    score = '0;
    dividend = '0;
    divisor = {{(QW-1){1'b0}}, 1'b1};
    if (!err) begin
      num      = HQ_W'(bs) * HQ_W'(sc) + HQ_W'(ss) * HQ_W'(bc);
      den      = (HQ_W'(bc) * HQ_W'(sc)) << 1;
      dividend = {num, {FRAC_W{1'b0}}};
      divisor  = {{FRAC_W{1'b0}}, den};
      score    = SCORE_W'(dividend / divisor);
    end
  end
endmodule

// File: rtl/wsc_window_scorer.sv
// Window scorer: load store, then a four-stage fixed-latency pipeline
// shape sum -> threshold -> masked counts -> hit quality.
module wsc_window_scorer
  import wsc_pkg::*;
#(
  parameter int DIM    = WSC_DIM,
  parameter int PIX_W  = WSC_PIX_W,
  parameter int BIAS_W = WSC_BIAS_W,
  parameter int FRAC_W = WSC_FRAC_W,
  localparam int CELLS   = DIM * DIM,
  localparam int CNT_W   = $clog2(CELLS + 1),
  localparam int SUM_W   = PIX_W + $clog2(CELLS),
  localparam int HQ_W    = $clog2(2 * CELLS * CELLS + 1),
  localparam int SCORE_W = FRAC_W + 1,
  localparam int TH_W    = ((SUM_W > BIAS_W) ? SUM_W : BIAS_W) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DIM*PIX_W-1:0]     in_pix,
  input  logic [DIM-1:0]           in_bright,
  input  logic [DIM-1:0]           in_surr,
  input  logic signed [BIAS_W-1:0] bias,
  input  logic                     start,
  output logic                     done,
  output logic                     err,
  output logic [CNT_W-1:0]         bright_cnt,
  output logic [CNT_W-1:0]         surr_cnt,
  output logic [HQ_W-1:0]          hq_num,
  output logic [HQ_W-1:0]          hq_den,
  output logic [SCORE_W-1:0]       hq_score
);
  logic [DIM-1:0][DIM*PIX_W-1:0] pix_rows;
  logic [DIM-1:0][DIM-1:0]       bmask_rows, smask_rows;
  logic [CNT_W-1:0]              bc, sc;

  logic v1, v2, v3, busy, start_ok, wr;
  logic [SUM_W-1:0]              sum_d, sum_q, avg, divisor;
  logic signed [BIAS_W-1:0]      bias_q;
  logic signed [TH_W-1:0]        thr_d, thr_q;
  logic [CNT_W-1:0]              bs_d, ss_d, bs_q, ss_q;
  logic                          q_err;
  logic [HQ_W-1:0]               q_num, q_den;
  logic [SCORE_W-1:0]            q_score;

  assign busy     = v1 | v2 | v3;
  assign start_ok = start & ~busy;
  assign in_ready = ~busy & ~start;
  assign wr       = in_valid & in_ready;

  wsc_loader #(.DIM(DIM), .PIX_W(PIX_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .wr(wr),
    .row_pix(in_pix), .row_bright(in_bright), .row_surr(in_surr),
    .pix_rows(pix_rows), .bmask_rows(bmask_rows), .smask_rows(smask_rows),
    .bc(bc), .sc(sc)
  );

  wsc_shape_sum #(.DIM(DIM), .PIX_W(PIX_W)) u_sum (
    .pix_rows(pix_rows), .bmask_rows(bmask_rows), .sum(sum_d)
  );

  // Stage 2 logic: threshold from the registered shape sum.
  assign divisor = (bc == '0) ? SUM_W'(1) : SUM_W'(bc);
  assign avg     = sum_q / divisor;
  assign thr_d   = $signed({{(TH_W-SUM_W){1'b0}}, avg})
                 - $signed({{(TH_W-BIAS_W){bias_q[BIAS_W-1]}}, bias_q});

  wsc_masked_count #(.DIM(DIM), .PIX_W(PIX_W), .TH_W(TH_W)) u_count (
    .pix_rows(pix_rows), .bmask_rows(bmask_rows), .smask_rows(smask_rows),
    .thr(thr_q), .bs(bs_d), .ss(ss_d)
  );

  wsc_quality #(.DIM(DIM), .FRAC_W(FRAC_W)) u_quality (
    .bs(bs_q), .ss(ss_q), .bc(bc), .sc(sc),
    .err(q_err), .num(q_num), .den(q_den), .score(q_score)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      done <= 1'b0;
      sum_q <= '0;
      bias_q <= '0;
      thr_q <= '0;
      bs_q <= '0;
      ss_q <= '0;
    end else begin
      v1 <= start_ok;
      v2 <= v1;
      v3 <= v2;
      done <= v3;
      if (start_ok) begin
        sum_q  <= sum_d;
        bias_q <= bias;
      end
      if (v1) thr_q <= thr_d;
      if (v2) begin
        bs_q <= bs_d;
        ss_q <= ss_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err        <= 1'b0;
      bright_cnt <= '0;
      surr_cnt   <= '0;
      hq_num     <= '0;
      hq_den     <= '0;
      hq_score   <= '0;
    end else if (v3) begin
      err        <= q_err;
      bright_cnt <= q_err ? '0 : bs_q;
      surr_cnt   <= q_err ? '0 : ss_q;
      hq_num     <= q_num;
      hq_den     <= q_den;
      hq_score   <= q_score;
    end
  end
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int HQ_W    = 14,
  parameter int FRAC_W  = 16,
  parameter int SCORE_W = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               start,
  input logic               done,
  input logic               err,
  input logic [HQ_W-1:0]    hq_num,
  input logic [HQ_W-1:0]    hq_den,
  input logic [SCORE_W-1:0] hq_score
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start, 4)); // R3
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(!in_ready)); // R2
  AST_NUM_LE_DEN: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> (hq_num <= hq_den)); // R7
  AST_SCORE_MAX: assert property (@(posedge clk) disable iff (!rst_n) done |-> (hq_score <= {1'b1, {FRAC_W{1'b0}}})); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> (hq_score == '0 && hq_num == '0 && hq_den == '0)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(hq_score) && $stable(err) && $stable(hq_num))); // R10
endmodule

bind wsc_window_scorer wsc_checker #(.HQ_W(HQ_W), .FRAC_W(FRAC_W), .SCORE_W(SCORE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .start(start), .done(done),
  .err(err), .hq_num(hq_num), .hq_den(hq_den), .hq_score(hq_score)
);

// File: tb/wsc_window_scorer_tb.sv
module wsc_window_scorer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_pix = '0;
  logic [7:0] in_bright = '0, in_surr = '0;
  logic signed [11:0] bias = '0;
  logic start = 1'b0;
  logic done, err;
  logic [6:0] bright_cnt, surr_cnt;
  logic [13:0] hq_num, hq_den;
  logic [16:0] hq_score;

  wsc_window_scorer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_bright(in_bright), .in_surr(in_surr), .bias(bias),
    .start(start), .done(done), .err(err), .bright_cnt(bright_cnt),
    .surr_cnt(surr_cnt), .hq_num(hq_num), .hq_den(hq_den), .hq_score(hq_score)
  );

  int checks = 0, errors = 0, cyc = 0;
  int tb_pix[64];
  bit tb_bm[64], tb_sm[64];
  int m_pix[64];
  bit m_bm[64], m_sm[64];
  int m_row = 0, m_age = 0;
  bit m_done = 0;
  longint e_err = 0, e_bs = 0, e_ss = 0, e_num = 0, e_den = 0, e_score = 0;
  longint p_err = 0, p_bs = 0, p_ss = 0, p_num = 0, p_den = 0, p_score = 0;
  int seed = 7;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural prediction from the mirrored window (R4..R9).
  task automatic predict(input longint bias_v);
    longint bc = 0, sc = 0, s = 0, thr;
    for (int i = 0; i < 64; i++) begin
      bc += m_bm[i];
      sc += m_sm[i];
      if (m_bm[i]) s += m_pix[i];
    end
    p_bs = 0; p_ss = 0; p_num = 0; p_den = 0; p_score = 0;
    p_err = (bc == 0 || sc == 0) ? 1 : 0;
    if (p_err == 0) begin
      thr = s / bc - bias_v;
      for (int i = 0; i < 64; i++) begin
        if (m_bm[i] && m_pix[i] >= thr) p_bs++;
        if (m_sm[i] && m_pix[i] < thr) p_ss++;
      end
      p_num = p_bs * sc + p_ss * bc;
      p_den = 2 * bc * sc;
      p_score = (p_num * 65536) / p_den;
    end
  endtask

  // Cycle model: load mirror, pipeline age, result registers.
  always @(posedge clk) begin
    bit acc_load, acc_start;
    if (!rst_n) begin
      m_row = 0; m_age = 0; m_done = 0;
      e_err = 0; e_bs = 0; e_ss = 0; e_num = 0; e_den = 0; e_score = 0;
    end else begin
      acc_load  = in_valid && (m_age == 0) && !start;
      acc_start = start && (m_age == 0);
      if (acc_load) begin
        for (int c = 0; c < 8; c++) begin
          m_pix[m_row*8+c] = int'(in_pix[c*8 +: 8]);
          m_bm[m_row*8+c]  = in_bright[c];
          m_sm[m_row*8+c]  = in_surr[c];
        end
        m_row = (m_row + 1) % 8;
      end
      if (acc_start) predict(longint'(bias));
      m_done = (m_age == 3);
      if (m_done) begin
        e_err = p_err; e_bs = p_bs; e_ss = p_ss;
        e_num = p_num; e_den = p_den; e_score = p_score;
      end
      m_age = (m_age == 0) ? (acc_start ? 1 : 0) : ((m_age == 3) ? 0 : m_age + 1);
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    chk("R3", "done", done, m_done);
    chk("R2", "in_ready", in_ready, (m_age == 0 && !start) ? 1 : 0);
    chk("R9", "err", err, e_err);
    chk("R1 R4 R5", "bright_cnt", bright_cnt, e_bs);
    chk("R1 R4 R6", "surr_cnt", surr_cnt, e_ss);
    chk("R7", "hq_num", hq_num, e_num);
    chk("R7", "hq_den", hq_den, e_den);
    chk("R8 R10", "hq_score", hq_score, e_score);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load_window();
    for (int r = 0; r < 8; r++) begin
      in_valid = 1'b1;
      for (int c = 0; c < 8; c++) begin
        in_pix[c*8 +: 8] = 8'(tb_pix[r*8+c]);
        in_bright[c] = tb_bm[r*8+c];
        in_surr[c] = tb_sm[r*8+c];
      end
      forever begin
        bit rdy;
        @(negedge clk);
        rdy = in_ready;
        @(posedge clk);
        #1;
        if (rdy) break;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic score();
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic pattern_a();
    for (int i = 0; i < 64; i++) begin
      tb_pix[i] = ((i / 8) * 37 + (i % 8) * 11) % 256;
      tb_bm[i] = (((i / 8) + (i % 8)) % 2 == 0);
      tb_sm[i] = !tb_bm[i];
    end
  endtask

  task automatic next_rand(output int v);
    seed = seed * 1103515245 + 12345;
    v = (seed >>> 8) & 32'h7fff_ffff;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R1 R4 R5 R6: checkerboard masks, varied pixels, zero bias.
    pattern_a(); bias = 12'sd0;
    load_window(); score();

    // R5 R6: pixels equal to the threshold count bright, fail surround.
    for (int i = 0; i < 64; i++) begin
      tb_pix[i] = 100; tb_bm[i] = (i < 32); tb_sm[i] = (i >= 32);
    end
    load_window(); score();

    // R8: full score 1.0 (bright on high pixels, surround on low).
    for (int i = 0; i < 64; i++) begin
      tb_bm[i] = (i % 3 == 0); tb_sm[i] = !tb_bm[i];
      tb_pix[i] = tb_bm[i] ? 200 : 10;
    end
    load_window(); score();

    // R5 R6: negative threshold through a large positive bias.
    pattern_a(); bias = 12'sd500;
    load_window(); score();

    // R5 R6: threshold above every pixel through a negative bias.
    for (int i = 0; i < 64; i++) begin tb_bm[i] = 1; tb_sm[i] = 1; end
    bias = -12'sd1000;
    load_window(); score();

    // R9: empty bright mask, then empty surround mask.
    bias = 12'sd0;
    for (int i = 0; i < 64; i++) begin tb_bm[i] = 0; tb_sm[i] = (i % 2 == 0); end
    load_window(); score();
    for (int i = 0; i < 64; i++) begin tb_bm[i] = (i % 5 == 0); tb_sm[i] = 0; end
    load_window(); score();

    // R3: second start during scoring is ignored, single done pulse.
    pattern_a(); bias = 12'sd3;
    load_window();
    start = 1'b1; @(posedge clk); #1 start = 1'b0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (5) @(posedge clk); #1;

    // R2: a beat offered right after start stalls and is not lost.
    start = 1'b1; @(posedge clk); #1 start = 1'b0;
    for (int i = 0; i < 64; i++) begin
      tb_pix[i] = (i * 29 + 5) % 256; tb_bm[i] = (i % 4 != 1); tb_sm[i] = (i % 4 == 1);
    end
    load_window();
    repeat (3) @(posedge clk); #1;
    bias = -12'sd2;
    score();

    // R1 R4..R8: pseudo-random windows and biases.
    for (int k = 0; k < 8; k++) begin
      int v;
      for (int i = 0; i < 64; i++) begin
        next_rand(v); tb_pix[i] = v % 256;
        next_rand(v); tb_bm[i] = (v % 3 == 0);
        next_rand(v); tb_sm[i] = !tb_bm[i] && (v % 2 == 0);
      end
      next_rand(v);
      bias = 12'((v % 81) - 40);
      load_window(); score();
    end

    repeat (3) @(posedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule